// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

The engine takes packets arriving one byte per beat on a valid/ready stream and stores them in host memory buffers. A ring of two-word descriptors in memory describes those buffers. Each descriptor is two 32-bit words at consecutive word addresses. The word at the descriptor address carries the flags and the buffer length. The word at descriptor address + 4 carries the buffer's byte address. The engine reads the current descriptor and checks that it owns it. It then fills the buffer with as many packet bytes as fit, and moves along the ring for the rest of the packet, writing a status word back over each descriptor it used.

Memory is reached through a single request/grant master port that carries 32-bit words. A packet that ends part way through a word, or a buffer that starts or ends at an unaligned byte address, is written with byte enables. Bytes outside the buffer are never touched. Software sees a small register window holding the ring base address, the current descriptor pointer and an interrupt-acknowledge location. The interrupt output is a level. It is raised once the descriptor that opened a packet has been updated, and it stays high until software acknowledges it.

Top module: `rxring_scatter`

## Requirements
- R1: If word 0 of the current descriptor has bit 31 (ownership) clear when a packet begins, every byte of the packet is accepted and discarded. No memory write takes place, the current pointer keeps its value and no interrupt is raised.
- R2: While the ring base register holds zero, an arriving packet is accepted and discarded without any memory request.
- R3: Each buffer receives min(buffer length, bytes still left in the packet) bytes, starting at the buffer address. The buffer length is bits 12:0 of word 0. A byte at address a sits in bits 8*a[1:0]+7 down to 8*a[1:0] of word a/4. Bytes next to the buffer are left unchanged.
- R4: When bytes remain after a buffer is full, word 0 of the next descriptor is read. If that word has bit 31 set, the status of the full descriptor becomes bit 27 (continue) OR its byte count. The next descriptor is at the ring base if the current word 0 has bit 30 (wrap) set, and at the current address + 8 otherwise.
- R5: The descriptor holding the last stored byte of a packet gets status = its byte count + 4, with all flag bits clear.
- R6: If the next descriptor is not owned, the full descriptor's status is its byte count alone and the packet ends there. The remaining bytes are discarded, the current pointer moves to that next descriptor, and that descriptor is not written.
- R7: A packet longer than 8192 bytes is stored as its first 8192 bytes, and the bytes beyond that are discarded.
- R8: The status of the first descriptor of a packet is written after the status of every later descriptor of that packet. The interrupt rises in the cycle after the grant of that write.
- R9: The interrupt stays high until a register write to offset 0x0C. If that write falls in the same cycle as a new interrupt being raised, the interrupt stays high.
- R10: Offset 0x04 (ring base) and offset 0x08 (current pointer) can be written and read back, and both read zero after reset. The current pointer advances past each descriptor the engine finishes. Reads of other offsets return zero.
- R11: At most one memory access is outstanding. A request keeps its address and direction until it is granted. Every address is word aligned, and a write carries at least one byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears in reg_rdata one cycle later |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Packet byte valid |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Engine accepts the byte on this edge |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, after a read's grant |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Packet-done interrupt, level |

## Verification
Two functions can fall in the same cycle: the interrupt raised when the grant for the packet's opening status write arrives, and a software acknowledge that clears it. The memory model in the bench watches for the write to the opening descriptor's address. In the same cycle it grants that write, it drives the acknowledge write onto the register port, so both act on one clock edge. The interrupt is then checked to be high, and a later acknowledge on its own is checked to bring it low.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int OWN_BIT  = 31;
  localparam int WRAP_BIT = 30;
  localparam int CONT_BIT = 27;
  localparam int LEN_W    = 13;
  localparam int DW       = 32;
  localparam int NB       = DW / 8;

  localparam logic [3:0] OFS_BASE = 4'h4;
  localparam logic [3:0] OFS_CUR  = 4'h8;
  localparam logic [3:0] OFS_ACK  = 4'hC;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DROP, ST_RD0, ST_RD1, ST_FILL,
    ST_WDAT, ST_NXT, ST_STAT, ST_FIRST
  } st_t;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cur_upd,
  input  logic [AW-1:0] cur_val,
  input  logic          irq_set,
  output logic [AW-1:0] base,
  output logic [AW-1:0] cur,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      cur       <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == OFS_BASE) base <= reg_wdata[AW-1:0];
      if (cur_upd) cur <= cur_val;
      else if (reg_we && reg_addr == OFS_CUR) cur <= reg_wdata[AW-1:0];
      if (irq_set) irq <= 1'b1;
      else if (reg_we && reg_addr == OFS_ACK) irq <= 1'b0;
      if (reg_re) begin
        case (reg_addr)
          OFS_BASE: reg_rdata <= DW'(base);
          OFS_CUR:  reg_rdata <= DW'(cur);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxs_lane.sv
module rxs_lane
  import rxs_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          put,
  input  logic          flush,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    byte_in,
  output logic [DW-1:0] word_nx,
  output logic [NB-1:0] be_nx
);
  logic [DW-1:0] acc;
  logic [NB-1:0] be_q;
  logic [NB-1:0] hit;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign hit[g]          = put && (lane == LW'(g));
    assign word_nx[g*8+:8] = hit[g] ? byte_in : acc[g*8+:8];
    assign be_nx[g]        = be_q[g] | hit[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      be_q <= '0;
    end else if (flush) begin
      be_q <= '0;
    end else if (put) begin
      acc  <= word_nx;
      be_q <= be_nx;
    end
  end
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_PKT = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] cur,
  output logic          cur_upd,
  output logic [AW-1:0] cur_val,
  output logic          irq_set,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [NB-1:0] mem_be,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          pk_put,
  output logic          pk_flush,
  output logic [1:0]    pk_lane,
  input  logic [DW-1:0] pk_word,
  input  logic [NB-1:0] pk_be
);
  localparam int CW = $clog2(MAX_PKT + 1);

  st_t              st;
  logic             wrap_q, nx_wrap;
  logic [LEN_W-1:0] len_q, nx_len, cnt_buf;
  logic [AW-1:0]    buf_addr, first_addr, nxt_addr;
  logic [CW-1:0]    pkt_cnt;
  logic [DW-1:0]    stat_q, first_stat;
  logic             is_first, last_q, full_q, drop_q, end_q;

  logic             gnt_hit, rd_done, eff_last, buf_full_now, stat_done;
  logic [AW-1:0]    nxt_ring, wa;
  logic [DW-1:0]    last_stat, nxt_stat;

  assign gnt_hit      = mem_req && mem_gnt;
  assign rd_done      = !mem_req && mem_rvalid;
  assign in_ready     = (st == ST_FILL) || (st == ST_DROP);
  assign pk_put       = (st == ST_FILL) && in_valid;
  assign wa           = buf_addr + AW'(cnt_buf);
  assign pk_lane      = wa[1:0];
  assign eff_last     = in_last || (pkt_cnt == CW'(MAX_PKT - 1));
  assign buf_full_now = ({1'b0, cnt_buf} + (LEN_W+1)'(1)) == {1'b0, len_q};
  assign pk_flush     = pk_put && (pk_lane == 2'd3 || eff_last || buf_full_now);
  assign nxt_ring     = wrap_q ? base : cur + AW'(8);
  assign last_stat    = DW'(cnt_buf) + DW'(4);
  assign nxt_stat     = (mem_rdata[OWN_BIT] ? (DW'(1) << CONT_BIT) : '0) | DW'(cnt_buf);
  assign stat_done    = (st == ST_STAT) && (is_first || gnt_hit);
  assign cur_upd      = stat_done;
  assign cur_val      = nxt_addr;
  assign irq_set      = (st == ST_FIRST) && gnt_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0; mem_be <= '0;
      wrap_q <= 1'b0; nx_wrap <= 1'b0; len_q <= '0; nx_len <= '0; cnt_buf <= '0;
      buf_addr <= '0; first_addr <= '0; nxt_addr <= '0; pkt_cnt <= '0;
      stat_q <= '0; first_stat <= '0;
      is_first <= 1'b0; last_q <= 1'b0; full_q <= 1'b0; drop_q <= 1'b0; end_q <= 1'b0;
    end else begin
      if (gnt_hit) mem_req <= 1'b0;
      case (st)
        ST_IDLE: if (in_valid) begin
          if (base == '0) st <= ST_DROP;
          else begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= cur; mem_be <= '1;
            st <= ST_RD0;
          end
        end
        ST_DROP: if (in_valid && in_last) st <= ST_IDLE;
        ST_RD0: if (rd_done) begin
          if (!mem_rdata[OWN_BIT]) st <= ST_DROP;
          else begin
            wrap_q <= mem_rdata[WRAP_BIT];
            len_q <= mem_rdata[LEN_W-1:0];
            first_addr <= cur; is_first <= 1'b1; pkt_cnt <= '0; drop_q <= 1'b0;
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= cur + AW'(4);
            st <= ST_RD1;
          end
        end
        ST_RD1: if (rd_done) begin
          buf_addr <= mem_rdata[AW-1:0];
          cnt_buf <= '0;
          if (len_q == '0) begin
            nxt_addr <= nxt_ring;
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= nxt_ring;
            st <= ST_NXT;
          end else st <= ST_FILL;
        end
        ST_FILL: if (pk_put) begin
          cnt_buf <= cnt_buf + LEN_W'(1);
          pkt_cnt <= pkt_cnt + CW'(1);
          last_q <= eff_last;
          full_q <= buf_full_now;
          drop_q <= eff_last && !in_last;
          if (pk_flush) begin
            mem_req <= 1'b1; mem_we <= 1'b1;
            mem_addr <= {wa[AW-1:2], 2'b00};
            mem_wdata <= pk_word; mem_be <= pk_be;
            st <= ST_WDAT;
          end
        end
        ST_WDAT: if (gnt_hit) begin
          if (last_q) begin
            stat_q <= last_stat; end_q <= 1'b1; nxt_addr <= nxt_ring;
            if (!is_first) begin
              mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur;
              mem_wdata <= last_stat; mem_be <= '1;
            end
            st <= ST_STAT;
          end else if (full_q) begin
            nxt_addr <= nxt_ring;
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= nxt_ring;
            st <= ST_NXT;
          end else st <= ST_FILL;
        end
        ST_NXT: if (rd_done) begin
          stat_q <= nxt_stat;
          end_q <= !mem_rdata[OWN_BIT];
          drop_q <= !mem_rdata[OWN_BIT];
          nx_wrap <= mem_rdata[WRAP_BIT];
          nx_len <= mem_rdata[LEN_W-1:0];
          if (!is_first) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur;
            mem_wdata <= nxt_stat; mem_be <= '1;
          end
          st <= ST_STAT;
        end
        ST_STAT: if (stat_done) begin
          if (is_first) first_stat <= stat_q;
          if (end_q) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= first_addr;
            mem_wdata <= is_first ? stat_q : first_stat; mem_be <= '1;
            st <= ST_FIRST;
          end else begin
            is_first <= 1'b0; wrap_q <= nx_wrap; len_q <= nx_len;
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= nxt_addr + AW'(4);
            st <= ST_RD1;
          end
        end
        ST_FIRST: if (gnt_hit) begin
          end_q <= 1'b0;
          st <= drop_q ? ST_DROP : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_scatter.sv
module rxring_scatter
  import rxs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_PKT = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  logic [AW-1:0] base, cur, cur_val;
  logic          cur_upd, irq_set, pk_put, pk_flush;
  logic [1:0]    pk_lane;
  logic [DW-1:0] pk_word;
  logic [NB-1:0] pk_be;

  rxs_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_upd(cur_upd), .cur_val(cur_val),
    .irq_set(irq_set), .base(base), .cur(cur), .irq(irq)
  );

  rxs_lane #(.LW(2)) u_lane (
    .clk(clk), .rst(rst), .put(pk_put), .flush(pk_flush), .lane(pk_lane),
    .byte_in(in_data), .word_nx(pk_word), .be_nx(pk_be)
  );

  rxs_ctrl #(.AW(AW), .MAX_PKT(MAX_PKT)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .base(base), .cur(cur), .cur_upd(cur_upd), .cur_val(cur_val), .irq_set(irq_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pk_put(pk_put), .pk_flush(pk_flush), .pk_lane(pk_lane), .pk_word(pk_word), .pk_be(pk_be)
  );
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          irq,
  input logic          reg_we,
  input logic [3:0]    reg_addr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R11
  AST_WR_BE: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_be != 4'b0000); // R11
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (rst)
    irq && !(reg_we && reg_addr == 4'hC) |=> irq); // R9
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == 4'hC && !(mem_req && mem_we && mem_gnt) |=> !irq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_req && mem_we && mem_gnt)); // R8
endmodule

bind rxring_scatter rxs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_be(mem_be), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/sim_rxring_scatter.sv
module sim_rxring_scatter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        reg_we_t = 0, reg_re = 0, clr_pulse = 0;
  logic [3:0]  reg_addr_t = 0;
  logic [31:0] reg_wdata_t = 0, reg_rdata;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        in_valid = 0, in_last = 0, in_ready;
  logic [7:0]  in_data = 0;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  assign reg_we    = reg_we_t | clr_pulse;
  assign reg_addr  = clr_pulse ? 4'hC : reg_addr_t;
  assign reg_wdata = reg_wdata_t;

  rxring_scatter u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [0:4095];
  int req_total = 0, wr_total = 0, idx_a = 0, idx_b = 0;
  logic [31:0] watch_a = 32'hFFFF_FFFF, watch_b = 32'hFFFF_FFFF, collide_addr = 0, rd_addr = 0;
  logic rd_pend = 0, collide_arm = 0;

  // memory model: grants at the falling edge, read data one cycle after the grant
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0; clr_pulse = 0;
      if (rd_pend) begin mem_rvalid = 1; mem_rdata = mem[rd_addr[13:2]]; rd_pend = 0; end
      if (mem_req === 1'b1 && !mem_gnt) begin
        mem_gnt = 1; req_total++;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[13:2]][b*8+:8] = mem_wdata[b*8+:8];
          wr_total++;
          if (mem_addr == watch_a) idx_a = wr_total;
          if (mem_addr == watch_b) idx_b = wr_total;
          if (collide_arm && mem_addr == collide_addr) begin clr_pulse = 1; collide_arm = 0; end
        end else begin
          rd_pend = 1; rd_addr = mem_addr;
        end
      end else mem_gnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(i * 7 + seed * 31 + (i >> 8));
  endfunction

  function automatic logic [7:0] rd8(input logic [31:0] a);
    return mem[a[13:2]][a[1:0]*8+:8];
  endfunction

  task automatic fill(input logic [31:0] a, input int nwords);
    for (int k = 0; k < nwords; k++) mem[a[13:2] + 12'(k)] = 32'hAAAA_AAAA;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we_t = 1; reg_addr_t = a; reg_wdata_t = d;
    @(negedge clk); reg_we_t = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr_t = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic send_pkt(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat(seed, i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 irq after reset", 32'(irq), 0);
    chk("R11 no request after reset", 32'(mem_req), 0);
    reg_rd(4'h4, v); chk("R10 base after reset", v, 0);
    reg_rd(4'h8, v); chk("R10 cur after reset", v, 0);
  endtask

  task automatic t_base_zero();
    int r0;
    reg_wr(4'h8, 32'h100);
    mem[12'h40] = 32'h8000_0040;
    r0 = req_total;
    send_pkt(9, 5);
    repeat (10) @(negedge clk);
    chk("R2 no memory request", 32'(req_total - r0), 0);
    chk("R2 no interrupt", 32'(irq), 0);
    chk("R2 descriptor unchanged", mem[12'h40], 32'h8000_0040);
  endtask

  task automatic t_not_owned();
    int w0; logic [31:0] v;
    reg_wr(4'h4, 32'h100);
    mem[12'h40] = 32'h0000_0040;
    w0 = wr_total;
    send_pkt(8, 6);
    repeat (10) @(negedge clk);
    chk("R1 no memory write", 32'(wr_total - w0), 0);
    chk("R1 no interrupt", 32'(irq), 0);
    reg_rd(4'h8, v); chk("R1 pointer kept", v, 32'h100);
  endtask

  task automatic t_single();
    logic [31:0] v; logic [31:0] ok;
    mem[12'h40] = 32'h8000_0040; mem[12'h41] = 32'h400;
    fill(32'h400, 16);
    send_pkt(1, 10);
    wait_irq();
    ok = 1;
    for (int i = 0; i < 10; i++) if (rd8(32'h400 + 32'(i)) !== pat(1, i)) ok = 0;
    chk("R3 single buffer data", ok, 1);
    chk("R3 byte past packet untouched", 32'(rd8(32'h40A)), 32'hAA);
    chk("R5 last status count+4", mem[12'h40], 32'd14);
    chk("R8 interrupt raised", 32'(irq), 1);
    reg_rd(4'h8, v); chk("R10 pointer advanced", v, 32'h108);
    reg_wr(4'hC, 0);
    @(negedge clk);
    chk("R9 acknowledge clears", 32'(irq), 0);
  endtask

  task automatic t_chain_wrap();
    logic [31:0] v; logic [31:0] ok;
    mem[12'h42] = 32'h8000_0006; mem[12'h43] = 32'h502;
    mem[12'h44] = 32'hC000_0040; mem[12'h45] = 32'h600;
    fill(32'h500, 4); fill(32'h600, 4);
    watch_a = 32'h108; watch_b = 32'h110; idx_a = 0; idx_b = 0;
    send_pkt(2, 9);
    wait_irq();
    ok = 1;
    for (int i = 0; i < 6; i++) if (rd8(32'h502 + 32'(i)) !== pat(2, i)) ok = 0;
    for (int i = 0; i < 3; i++) if (rd8(32'h600 + 32'(i)) !== pat(2, 6 + i)) ok = 0;
    chk("R3 split data", ok, 1);
    chk("R3 byte before buffer untouched", 32'(rd8(32'h501)), 32'hAA);
    chk("R3 byte after full buffer untouched", 32'(rd8(32'h508)), 32'hAA);
    chk("R4 continue status", mem[12'h42], 32'h0800_0006);
    chk("R5 tail status", mem[12'h44], 32'd7);
    chk("R8 head written last", 32'(idx_b < idx_a && idx_b != 0), 1);
    reg_rd(4'h8, v); chk("R4 wrap to ring base", v, 32'h100);
    reg_wr(4'hC, 0);
  endtask

  task automatic t_next_not_owned();
    logic [31:0] v;
    mem[12'h40] = 32'h8000_0004; mem[12'h41] = 32'h700;
    mem[12'h42] = 32'h0000_0000;
    fill(32'h700, 4);
    send_pkt(3, 10);
    wait_irq();
    chk("R6 status without continue", mem[12'h40], 32'd4);
    chk("R6 buffer holds 4 bytes", {rd8(32'h703), rd8(32'h700)}, {pat(3, 3), pat(3, 0)});
    chk("R6 no byte beyond buffer", 32'(rd8(32'h704)), 32'hAA);
    chk("R6 next descriptor untouched", mem[12'h42], 0);
    reg_rd(4'h8, v); chk("R6 pointer at next", v, 32'h108);
    reg_wr(4'hC, 0);
  endtask

  task automatic t_collide();
    reg_wr(4'h8, 32'h100);
    mem[12'h40] = 32'h8000_0020; mem[12'h41] = 32'h800;
    collide_addr = 32'h100; collide_arm = 1;
    send_pkt(5, 4);
    wait_irq();
    repeat (2) @(negedge clk);
    chk("R9 raise wins over acknowledge", 32'(irq), 1);
    chk("R5 status of short packet", mem[12'h40], 32'd8);
    reg_wr(4'hC, 0);
    @(negedge clk);
    chk("R9 later acknowledge clears", 32'(irq), 0);
  endtask

  task automatic t_trunc();
    logic [31:0] v;
    reg_wr(4'h8, 32'h100);
    mem[12'h40] = 32'h8000_1F40; mem[12'h41] = 32'h1000;
    mem[12'h42] = 32'hC000_03E8; mem[12'h43] = 32'h3000;
    fill(32'h3000, 256);
    send_pkt(4, 8200);
    wait_irq();
    chk("R7 head status", mem[12'h40], 32'h0800_1F40);
    chk("R7 tail holds 192 bytes", mem[12'h42], 32'd196);
    chk("R7 last stored byte", 32'(rd8(32'h30BF)), 32'(pat(4, 8191)));
    chk("R7 byte 8192 discarded", 32'(rd8(32'h30C0)), 32'hAA);
    chk("R3 first buffer start", 32'(rd8(32'h1000)), 32'(pat(4, 0)));
    reg_rd(4'h8, v); chk("R7 pointer wrapped", v, 32'h100);
    reg_wr(4'hC, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_wr(4'h4, 32'h0000_0F00); reg_wr(4'h8, 32'h0000_0F08);
    reg_rd(4'h4, v); chk("R10 base readback", v, 32'h0F00);
    reg_rd(4'h8, v); chk("R10 cur readback", v, 32'h0F08);
    reg_rd(4'h0, v); chk("R10 other offset reads zero", v, 0);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_base_zero();
    t_not_owned();
    t_single();
    t_chain_wrap();
    t_next_not_owned();
    t_collide();
    t_trunc();
    t_regs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule